// File: doc/BRIEF.md
# Hot-Insertion Bus Connection Controller

This synchronous controller decides when a card-side two-wire bus segment may be joined to a live backplane segment. It watches a supply-good flag, an enable input and the clock and data levels of both segments. It drives three outputs: a connect strobe for the buffer switches, an enable for the backplane precharge source, and an open-drain style ready flag.

After the supply is good and the enable is high, the controller waits for the bus to reach a safe point. It accepts one of two safe points. The first is a stop condition seen on the backplane while the card side is quiet. The second is a long stretch during which all four lines stay high. The controller also waits out a minimum enable-to-ready delay. It then releases ready, and after a further short delay it closes the link. When enable or the supply is withdrawn, ready and the link drop together.

All delays are parameters given in clock cycles. All line inputs, the supply flag and the enable pass through two-flop synchronizers, so any input change reaches the outputs no sooner than the third clock edge.

Top module: `hotplug_link_ctrl`

## Requirements
- R1: While the synchronized supply flag is low, the controller holds connect_o=0, ready_od_o=0 and precharge_o=1, and no enable or line activity changes these outputs.
- R2: If supply_ok_i falls at any time, including while linked, connect_o and ready_od_o are both 0 and precharge_o is 1 on the third clock edge after the change.
- R3: With the supply good and enable_i low, the controller is in standby: connect_o=0, ready_od_o=0 and precharge_o=0.
- R4: While the controller waits for a safe point after enable (ready_od_o=0), precharge_o=1 and connect_o=0.
- R5: A stop condition is a 0-to-1 change of bp_sda_i while bp_scl_i is 1, with card_scl_i and card_sda_i both 1 in the same sample. Once the enable delay has elapsed, such a stop releases ready on the fourth edge after the bp_sda_i rise.
- R6: A stop condition seen while either card-side line is 0 does not qualify. Random backplane traffic that changes data only while the clock is low never qualifies.
- R7: If all four lines stay 1 for IDLE_CYC consecutive synchronized samples, the bus qualifies. Any 0 on any line restarts the count, so ready follows IDLE_CYC+3 edges after the last release of a line.
- R8: Ready is released no earlier than EN_RDY_CYC+3 edges after enable_i rises, even when a stop has already been seen, and only after the bus qualifies.
- R9: connect_o rises RDY_CONN_CYC edges after ready_od_o rises. precharge_o is 0 while connected, and connect_o is never 1 while ready_od_o is 0.
- R10: When enable_i falls, ready_od_o and connect_o both fall on the same edge, the third edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_ok_i | input | 1 | Supply above the lockout threshold |
| enable_i | input | 1 | Request to join the segments |
| bp_scl_i | input | 1 | Backplane clock line level |
| bp_sda_i | input | 1 | Backplane data line level |
| card_scl_i | input | 1 | Card clock line level |
| card_sda_i | input | 1 | Card data line level |
| connect_o | output | 1 | Closes the buffer switches |
| precharge_o | output | 1 | Enables backplane precharge |
| ready_od_o | output | 1 | 0 = ready pulled low, 1 = released (link ready) |

## Verification
The hardest case to reach is a stop condition that must qualify or must be rejected on purpose while ordinary traffic never qualifies by chance. The random backplane traffic therefore changes data only while the clock is low. It keeps the clock high for at most six cycles, so neither a stop nor an idle window forms by accident. Directed steps then add a real stop, a stop with the card clock held low, an early stop that must wait for the enable delay, and a brief low pulse in the middle of an idle window.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic [2:0] {
    ST_LOCK  = 3'd0,
    ST_STBY  = 3'd1,
    ST_WATCH = 3'd2,
    ST_ARM   = 3'd3,
    ST_LINK  = 3'd4
  } link_state_e;
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_i[g];
        s2 <= s1;
      end
    end
    assign q_o[g] = s2;
  end
endmodule

// File: rtl/hp_bus_watch.sv
module hp_bus_watch #(
  parameter int IDLE_CYC = 4750
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic bp_scl_i,
  input  logic bp_sda_i,
  input  logic card_scl_i,
  input  logic card_sda_i,
  output logic qual_o
);
  localparam int CW = $clog2(IDLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_CYC - 1);

  logic          sda_prev;
  logic [CW-1:0] idle_cnt;
  logic          all_hi, stop_w, idle_hit;

  assign all_hi   = bp_scl_i & bp_sda_i & card_scl_i & card_sda_i;
  // stop: data rises under a high clock, card side quiet in the same sample
  assign stop_w   = arm_i & bp_scl_i & bp_sda_i & ~sda_prev & card_scl_i & card_sda_i;
  assign idle_hit = arm_i & all_hi & (idle_cnt == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_prev <= 1'b0;
      idle_cnt <= '0;
      qual_o   <= 1'b0;
    end else begin
      sda_prev <= bp_sda_i;
      if (!arm_i || !all_hi)    idle_cnt <= '0;
      else if (idle_cnt != LAST) idle_cnt <= idle_cnt + 1'b1;
      qual_o <= arm_i & (qual_o | stop_w | idle_hit);
    end
  end

  AST_IDLE_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_cnt <= LAST); // R7
  AST_QUAL_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> !qual_o); // R4
endmodule

// File: rtl/hp_seq.sv
module hp_seq
  import hp_pkg::*;
#(
  parameter int EN_RDY_CYC   = 4750,
  parameter int RDY_CONN_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sup_i,
  input  logic en_i,
  input  logic qual_i,
  output logic watch_o,
  output logic connect_o,
  output logic precharge_o,
  output logic ready_o
);
  localparam int MAXC = (EN_RDY_CYC > RDY_CONN_CYC) ? EN_RDY_CYC : RDY_CONN_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] EN_LAST   = CW'(EN_RDY_CYC - 1);
  localparam logic [CW-1:0] CONN_LAST = CW'(RDY_CONN_CYC - 1);

  link_state_e   state_q, state_d;
  logic [CW-1:0] dly_q, dly_d;

  always_comb begin
    state_d = state_q;
    dly_d   = dly_q;
    if (!sup_i) begin
      state_d = ST_LOCK;
      dly_d   = '0;
    end else if (!en_i) begin
      state_d = ST_STBY;
      dly_d   = '0;
    end else begin
      unique case (state_q)
        ST_LOCK, ST_STBY: begin
          state_d = ST_WATCH;
          dly_d   = '0;
        end
        ST_WATCH: begin
          if (dly_q == EN_LAST && qual_i) begin
            state_d = ST_ARM;
            dly_d   = '0;
          end else if (dly_q != EN_LAST) begin
            dly_d = dly_q + 1'b1;
          end
        end
        ST_ARM: begin
          if (dly_q == CONN_LAST) begin
            state_d = ST_LINK;
            dly_d   = '0;
          end else begin
            dly_d = dly_q + 1'b1;
          end
        end
        default: state_d = ST_LINK;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOCK;
      dly_q   <= '0;
    end else begin
      state_q <= state_d;
      dly_q   <= dly_d;
    end
  end

  assign watch_o     = (state_q == ST_WATCH);
  assign connect_o   = (state_q == ST_LINK);
  assign ready_o     = (state_q == ST_ARM) || (state_q == ST_LINK);
  assign precharge_o = (state_q == ST_LOCK) || (state_q == ST_WATCH) || (state_q == ST_ARM);

  AST_LOCKOUT_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sup_i |=> (!connect_o && !ready_o && precharge_o)); // R2
  AST_STANDBY_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sup_i && !en_i) |=> (!connect_o && !ready_o && !precharge_o)); // R3
  AST_READY_NEEDS_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(qual_i)); // R8
  AST_LINK_AFTER_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(connect_o) |-> $past(ready_o)); // R9
endmodule

// File: rtl/hotplug_link_ctrl.sv
module hotplug_link_ctrl #(
  parameter int IDLE_CYC     = 4750,
  parameter int EN_RDY_CYC   = 4750,
  parameter int RDY_CONN_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic enable_i,
  input  logic bp_scl_i,
  input  logic bp_sda_i,
  input  logic card_scl_i,
  input  logic card_sda_i,
  output logic connect_o,
  output logic precharge_o,
  output logic ready_od_o
);
  localparam int NSYNC = 6;

  logic [NSYNC-1:0] raw, syn;
  logic watch, qual, ready;

  assign raw = {supply_ok_i, enable_i, bp_scl_i, bp_sda_i, card_scl_i, card_sda_i};

  hp_sync #(.W(NSYNC)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  hp_bus_watch #(.IDLE_CYC(IDLE_CYC)) u_watch (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(watch),
    .bp_scl_i(syn[3]), .bp_sda_i(syn[2]),
    .card_scl_i(syn[1]), .card_sda_i(syn[0]),
    .qual_o(qual)
  );

  hp_seq #(.EN_RDY_CYC(EN_RDY_CYC), .RDY_CONN_CYC(RDY_CONN_CYC)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .sup_i(syn[5]), .en_i(syn[4]),
    .qual_i(qual), .watch_o(watch), .connect_o(connect_o),
    .precharge_o(precharge_o), .ready_o(ready)
  );

  assign ready_od_o = ready;

  AST_LINK_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    connect_o |-> ready_od_o); // R9
  AST_LINK_NO_PRECHARGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    connect_o |-> !precharge_o); // R9
endmodule

// File: tb/sim_hotplug_link_ctrl.sv
module sim_hotplug_link_ctrl;
  localparam int IDLE = 48;
  localparam int ENR  = 40;
  localparam int RCON = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sup = 0, en = 0, bscl = 1, bsda = 1, cscl = 1, csda = 1;
  logic conn, pre, rdy;
  int   errs = 0, checks = 0;
  bit   done = 0;

  always #10 clk = ~clk;

  hotplug_link_ctrl #(.IDLE_CYC(IDLE), .EN_RDY_CYC(ENR), .RDY_CONN_CYC(RCON)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(sup), .enable_i(en),
    .bp_scl_i(bscl), .bp_sda_i(bsda), .card_scl_i(cscl), .card_sda_i(csda),
    .connect_o(conn), .precharge_o(pre), .ready_od_o(rdy)
  );

  function automatic int max2(int a, int b); return (a > b) ? a : b; endfunction
  // edges from enable rise to ready with the bus already idle
  function automatic int lat_idle_from_en(); return 3 + max2(ENR, IDLE + 1); endfunction
  function automatic int lat_stop(); return 4; endfunction
  function automatic int lat_idle_from_release(); return IDLE + 3; endfunction
  function automatic int lat_en_only(); return ENR + 3; endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic drv();
    @(negedge clk);
  endtask

  // counts edges until ready rises (or limit)
  task automatic wait_rdy(int lim, output int n);
    n = 0;
    while (n < lim) begin
      cyc(1); n++;
      if (rdy) break;
    end
  endtask

  task automatic outs(string req, logic c, logic p, logic r);
    chk({req, " connect"}, conn, c);
    chk({req, " precharge"}, pre, p);
    chk({req, " ready"}, rdy, r);
  endtask

  // backplane traffic: data moves only while clock low, clock high <= 6 cycles
  task automatic traffic(int n);
    for (int i = 0; i < n; i++) begin
      bscl = 0;
      repeat (1 + $urandom_range(3)) begin bsda = 1'($urandom_range(1)); drv(); end
      bscl = 1;
      repeat (1 + $urandom_range(5)) drv();
    end
    bscl = 0; drv(); bsda = 0; drv(); bscl = 1; drv();
  endtask

  task automatic relink();
    int n;
    en = 0; cyc(5); drv();
    bscl = 1; bsda = 1; cscl = 1; csda = 1; en = 1;
    wait_rdy(200, n);
    cyc(RCON + 2); drv();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int n, m;
    void'($urandom(32'd1234));
    cyc(3); drv(); rst_n = 1;
    cyc(1);
    outs("R1 reset", 0, 1, 0);

    // R1: supply low ignores everything
    en = 1; drv();
    traffic(20); bsda = 1; drv();
    cyc(IDLE * 3);
    outs("R1 lockout", 0, 1, 0);

    // R3: standby
    en = 0; drv(); sup = 1; cyc(10);
    outs("R3 standby", 0, 0, 0);

    // R7/R8 idle route from enable, R4 precharge while waiting, R9 connect delay
    drv(); en = 1;
    cyc(5);
    outs("R4 waiting", 0, 1, 0);
    wait_rdy(200, n);
    n += 5;
    chk("R7 idle ready latency", n, lat_idle_from_en());
    chk("R9 no connect at ready", conn, 0);
    m = 0;
    while (m < 50 && !conn) begin cyc(1); m++; end
    chk("R9 ready to connect", m, RCON);
    outs("R9 linked", 1, 0, 1);

    // R10: enable fall drops ready and connect together
    drv(); en = 0;
    cyc(2);
    chk("R10 ready held 2 edges", rdy, 1);
    cyc(1);
    chk("R10 ready low edge 3", rdy, 0);
    chk("R10 connect low edge 3", conn, 0);

    // R6: random traffic with quiet card side never qualifies
    drv(); en = 1; bscl = 0;
    traffic(40);
    chk("R6 traffic no ready", rdy, 0);
    // R5: real stop after enable delay
    bsda = 1; wait_rdy(20, n);
    chk("R5 stop latency", n, lat_stop());

    // R6: stop with card clock low rejected
    drv(); en = 0; cyc(4); drv();
    bscl = 1; bsda = 0; cscl = 0; en = 1;
    cyc(ENR + 10); drv();
    bsda = 1;
    cyc(IDLE * 2);
    chk("R6 card busy stop ignored", rdy, 0);
    drv(); cscl = 1;
    wait_rdy(200, n);
    chk("R7 idle after card release", n, lat_idle_from_release());

    // R8: early stop waits for enable delay
    drv(); en = 0; cyc(4); drv();
    bscl = 1; bsda = 0; cscl = 1; en = 1;
    cyc(5); drv(); bsda = 1; drv(); bsda = 0; n = 7;
    while (n < 200 && !rdy) begin cyc(1); n++; end
    chk("R8 enable delay bound", n, lat_en_only() + 1);

    // R7: short low pulse restarts idle count
    drv(); en = 0; cyc(4); drv();
    bscl = 1; bsda = 1; en = 1;
    cyc(30); drv(); csda = 0; drv(); drv(); csda = 1;
    wait_rdy(200, n);
    chk("R7 restart latency", n, lat_idle_from_release());

    // R2: supply drop while linked
    cyc(RCON + 2);
    chk("R2 linked before drop", conn, 1);
    drv(); sup = 0;
    cyc(2);
    chk("R2 still linked 2 edges", conn, 1);
    cyc(1);
    outs("R2 lockout", 0, 1, 0);
    drv(); sup = 1;
    relink();
    outs("R9 relinked", 1, 0, 1);

    // random enable/supply toggles: check lockout outputs follow supply
    for (int k = 0; k < 10; k++) begin
      drv(); sup = 1'($urandom_range(1)); en = 1'($urandom_range(1));
      cyc(IDLE + ENR + RCON + 10);
      if (!sup)      outs("R1 random", 0, 1, 0);
      else if (!en)  outs("R3 random", 0, 0, 0);
      else           outs("R9 random", 1, 0, 1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule